// File: doc/BRIEF.md
# Descriptor-Driven Register Snapshot Engine

This block reads a list of descriptors from a local word-addressed SRAM and, for each one, issues reads to target registers through a simple read-master port. A pass begins at SRAM word 0 when `start_i` is pulsed while the block is idle. Descriptor words come in two kinds. A base word selects a 16-byte-aligned region of the target address space. A span word carries two packed (offset step, word count) pairs that select runs of consecutive 32-bit registers inside that region. An all-zero word ends the list.

Each value that comes back is handled in one of two ways, selected when the pass starts. In capture mode it is written into the same SRAM, starting at a word index given on `data_base_i`, which is normally the list length so that the data lands right after the list. In stream mode it is presented for one cycle on a data-valid output, for a downstream checker to consume. The SRAM is external, single-port, with one cycle of read latency. List fetches and captured-data writes share that port one at a time.

Top module: `llw_walker`

## Requirements
- R1: A `start_i` pulse seen while idle begins a pass at list word 0. `busy_o` is high from the next cycle until the pass ends. `done_o` is high for exactly one cycle, the last busy cycle, and `busy_o` is low in the cycle after it. A `start_i` seen while busy has no effect on the pass.
- R2: A list word with bit 31 set is a base word. Its bits 27:0, shifted left by 4, become the current byte base, and the running word offset returns to zero.
- R3: Any other non-zero list word is a span word. Its pair in bits 15:0 is handled first, then its pair in bits 31:16. In each pair, bits 7:0 are an offset step in words and bits 14:8 are a word count. The step is first added to the running offset. The pair then issues `count` reads at byte address base + 4*(offset + k), for k = 0 .. count-1, in order.
- R4: A pair whose count is zero issues no read and leaves the running offset unchanged.
- R5: A list word equal to zero ends the pass. A list that starts with zero ends with no target read.
- R6: In capture mode, the i-th read value is written to SRAM word `data_base_i` + i, and nothing appears on the stream output.
- R7: In stream mode, each read value appears once on `stream_data_o` with `stream_valid_o` high for one cycle, in read order, and the SRAM is never written.
- R8: The read master keeps at most one read outstanding. A request stays valid, with a stable address, until it is accepted. No new request is raised until the response arrives.
- R9: In capture mode, if the write index has reached the last SRAM word plus one before a read would be issued, the pass stops without that read. If the list index passes the last SRAM word without finding a zero word, the pass also stops. Either case sets `overflow_o`, which is held until the next start, and `done_o` still pulses.
- R10: After reset the block is idle: busy, done, overflow, SRAM enable, read request and stream valid are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Starts a pass when idle |
| capture_i | input | 1 | Sampled at start: 1 = write values to SRAM, 0 = stream them out |
| data_base_i | input | RAM_AW | Sampled at start: first SRAM word for captured values |
| busy_o | output | 1 | Pass in progress |
| done_o | output | 1 | One-cycle end-of-pass pulse |
| overflow_o | output | 1 | Last pass stopped on SRAM exhaustion |
| ram_en_o | output | 1 | SRAM access enable |
| ram_we_o | output | 1 | SRAM write enable |
| ram_addr_o | output | RAM_AW | SRAM word address |
| ram_wdata_o | output | 32 | SRAM write data |
| ram_rdata_i | input | 32 | SRAM read data, one cycle after the read |
| rd_req_valid_o | output | 1 | Target read request valid |
| rd_req_ready_i | input | 1 | Target read request accepted |
| rd_req_addr_o | output | 32 | Target byte address |
| rd_rsp_valid_i | input | 1 | Read response valid |
| rd_rsp_data_i | input | 32 | Read response data |
| stream_valid_o | output | 1 | Streamed value valid |
| stream_data_o | output | 32 | Streamed value |

## Verification
A wrong running offset or base shows up as a wrong `rd_req_addr_o` on the very next request, so the bench compares the whole request address sequence against its own walk of the list. A slipped write pointer or a wrong mode latch shows up either as SRAM words out of place after `done_o` or as stream pulses appearing when they should not. A mishandled terminator, a mishandled zero-count pair or a mishandled overflow condition changes the number of reads, or the overflow flag, within the same pass.

// File: rtl/llw_pkg.sv
`timescale 1ns/1ps
package llw_pkg;
  localparam int WORD_W  = 32;
  localparam int DELTA_W = 8;
  localparam int CNT_W   = 7;
  localparam int BASE_W  = 28;
  localparam int OFF_W   = 16;

  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_DECODE, S_PAIR, S_REQ, S_RESP, S_WRITE, S_END
  } llw_state_t;

  typedef struct packed {
    logic [DELTA_W-1:0] delta;
    logic [CNT_W-1:0]   count;
  } llw_pair_t;

  function automatic logic llw_is_base(input logic [WORD_W-1:0] w);
    return w[WORD_W-1];
  endfunction

  function automatic logic llw_is_end(input logic [WORD_W-1:0] w);
    return (w == '0);
  endfunction

  // upper = 0 selects the low half-word pair, 1 the high one
  function automatic llw_pair_t llw_pick_pair(input logic [WORD_W-1:0] w,
                                              input logic upper);
    llw_pair_t p;
    p.delta = upper ? w[16 +: DELTA_W] : w[0 +: DELTA_W];
    p.count = upper ? w[24 +: CNT_W]   : w[8 +: CNT_W];
    return p;
  endfunction

  // byte address of word k of the current pair
  function automatic logic [WORD_W-1:0] llw_target(input logic [BASE_W-1:0] base,
                                                   input logic [OFF_W-1:0]  off,
                                                   input logic [CNT_W-1:0]  k);
    logic [OFF_W-1:0] idx;
    idx = off + OFF_W'(k);
    return {base, 4'b0000} + WORD_W'({idx, 2'b00});
  endfunction
endpackage

// File: rtl/llw_addr_gen.sv
`timescale 1ns/1ps
module llw_addr_gen
  import llw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              load_base,
  input  logic [BASE_W-1:0] base_in,
  input  logic              load_link,
  input  logic [WORD_W-1:0] link_in,
  input  logic              upper,
  input  logic              load_pair,
  input  logic              step,
  output logic [CNT_W-1:0]  pair_count,
  output logic              last_beat,
  output logic [WORD_W-1:0] rd_addr
);
  llw_pair_t         lo_q, hi_q, cur;
  logic [BASE_W-1:0] base_q;
  logic [OFF_W-1:0]  off_q;
  logic [CNT_W-1:0]  k_q, cnt_q;
  logic              unused_link;

  assign unused_link = link_in[31] ^ link_in[15];
  assign cur         = upper ? hi_q : lo_q;
  assign pair_count  = cur.count;
  assign last_beat   = ((k_q + 1'b1) == cnt_q);
  assign rd_addr     = llw_target(base_q, off_q, k_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0; hi_q <= '0; base_q <= '0; off_q <= '0; k_q <= '0; cnt_q <= '0;
    end else if (clear) begin
      lo_q <= '0; hi_q <= '0; base_q <= '0; off_q <= '0; k_q <= '0; cnt_q <= '0;
    end else begin
      if (load_base) begin
        base_q <= base_in;
        off_q  <= '0;
      end
      if (load_link) begin
        lo_q <= llw_pick_pair(link_in, 1'b0);
        hi_q <= llw_pick_pair(link_in, 1'b1);
      end
      if (load_pair && cur.count != '0) begin
        off_q <= off_q + OFF_W'(cur.delta);
        cnt_q <= cur.count;
        k_q   <= '0;
      end else if (step) begin
        k_q <= k_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/llw_sink.sv
`timescale 1ns/1ps
module llw_sink
  import llw_pkg::*;
#(
  parameter int RAM_AW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic [RAM_AW-1:0] data_base,
  input  logic              capture,
  input  logic              accept,
  input  logic [WORD_W-1:0] data_in,
  input  logic              advance,
  output logic              full,
  output logic [RAM_AW-1:0] wr_ptr,
  output logic [WORD_W-1:0] held_data,
  output logic              stream_valid,
  output logic [WORD_W-1:0] stream_data
);
  logic [RAM_AW:0]   ptr_q;
  logic [WORD_W-1:0] data_q;
  logic              sv_q;

  assign full         = ptr_q[RAM_AW];
  assign wr_ptr       = ptr_q[RAM_AW-1:0];
  assign held_data    = data_q;
  assign stream_valid = sv_q;
  assign stream_data  = data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      data_q <= '0;
      sv_q   <= 1'b0;
    end else begin
      sv_q <= accept && !capture;
      if (accept) data_q <= data_in;
      if (clear) ptr_q <= {1'b0, data_base};
      else if (advance) ptr_q <= ptr_q + 1'b1;
    end
  end
endmodule

// File: rtl/llw_walker.sv
`timescale 1ns/1ps
module llw_walker
  import llw_pkg::*;
#(
  parameter int RAM_AW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              capture_i,
  input  logic [RAM_AW-1:0] data_base_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              overflow_o,
  output logic              ram_en_o,
  output logic              ram_we_o,
  output logic [RAM_AW-1:0] ram_addr_o,
  output logic [WORD_W-1:0] ram_wdata_o,
  input  logic [WORD_W-1:0] ram_rdata_i,
  output logic              rd_req_valid_o,
  input  logic              rd_req_ready_i,
  output logic [WORD_W-1:0] rd_req_addr_o,
  input  logic              rd_rsp_valid_i,
  input  logic [WORD_W-1:0] rd_rsp_data_i,
  output logic              stream_valid_o,
  output logic [WORD_W-1:0] stream_data_o
);
  llw_state_t        state_q, state_d;
  logic [RAM_AW:0]   lptr_q;
  logic              half_q, cap_q, ovf_q;
  // named internal events, observed by the checker
  logic              ev_clear, ev_base, ev_link, ev_pair, ev_step;
  logic              ev_accept, ev_write, ev_beat, ev_lptr_inc;
  logic              ev_half_set, ev_half_clr, ev_ovf;
  logic [CNT_W-1:0]  pair_count;
  logic              last_beat, sink_full;
  logic [RAM_AW-1:0] wr_ptr;
  logic [WORD_W-1:0] held_data;
  logic              unused_rd;

  assign unused_rd = ^ram_rdata_i[30:28];

  always_comb begin
    state_d     = state_q;
    ev_clear    = 1'b0; ev_base = 1'b0; ev_link = 1'b0; ev_pair = 1'b0;
    ev_step     = 1'b0; ev_accept = 1'b0; ev_write = 1'b0; ev_beat = 1'b0;
    ev_lptr_inc = 1'b0; ev_half_set = 1'b0; ev_half_clr = 1'b0; ev_ovf = 1'b0;
    case (state_q)
      S_IDLE:   if (start_i) begin ev_clear = 1'b1; state_d = S_FETCH; end
      S_FETCH:  if (lptr_q[RAM_AW]) begin ev_ovf = 1'b1; state_d = S_END; end
                else state_d = S_DECODE;
      S_DECODE: begin
        if (llw_is_end(ram_rdata_i)) state_d = S_END;
        else begin
          ev_lptr_inc = 1'b1;
          if (llw_is_base(ram_rdata_i)) begin ev_base = 1'b1; state_d = S_FETCH; end
          else begin ev_link = 1'b1; ev_half_clr = 1'b1; state_d = S_PAIR; end
        end
      end
      S_PAIR: begin
        ev_pair = 1'b1;
        if (pair_count == '0) begin
          if (half_q) state_d = S_FETCH;
          else begin ev_half_set = 1'b1; state_d = S_PAIR; end
        end else state_d = S_REQ;
      end
      S_REQ: if (cap_q && sink_full) begin ev_ovf = 1'b1; state_d = S_END; end
             else if (rd_req_ready_i) state_d = S_RESP;
      S_RESP: if (rd_rsp_valid_i) begin
        ev_accept = 1'b1;
        if (cap_q) state_d = S_WRITE;
        else ev_beat = 1'b1;
      end
      S_WRITE: begin ev_write = 1'b1; ev_beat = 1'b1; end
      S_END:   state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
    if (ev_beat) begin
      if (last_beat) begin
        if (half_q) state_d = S_FETCH;
        else begin ev_half_set = 1'b1; state_d = S_PAIR; end
      end else begin
        ev_step = 1'b1;
        state_d = S_REQ;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      lptr_q  <= '0;
      half_q  <= 1'b0;
      cap_q   <= 1'b0;
      ovf_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (ev_clear) begin
        lptr_q <= '0;
        cap_q  <= capture_i;
        ovf_q  <= 1'b0;
        half_q <= 1'b0;
      end else begin
        if (ev_lptr_inc) lptr_q <= lptr_q + 1'b1;
        if (ev_half_clr) half_q <= 1'b0;
        else if (ev_half_set) half_q <= 1'b1;
        if (ev_ovf) ovf_q <= 1'b1;
      end
    end
  end

  llw_addr_gen u_addr (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (ev_clear),
    .load_base  (ev_base),
    .base_in    (ram_rdata_i[BASE_W-1:0]),
    .load_link  (ev_link),
    .link_in    (ram_rdata_i),
    .upper      (half_q),
    .load_pair  (ev_pair),
    .step       (ev_step),
    .pair_count (pair_count),
    .last_beat  (last_beat),
    .rd_addr    (rd_req_addr_o)
  );

  llw_sink #(.RAM_AW(RAM_AW)) u_sink (
    .clk          (clk),
    .rst_n        (rst_n),
    .clear        (ev_clear),
    .data_base    (data_base_i),
    .capture      (cap_q),
    .accept       (ev_accept),
    .data_in      (rd_rsp_data_i),
    .advance      (ev_write),
    .full         (sink_full),
    .wr_ptr       (wr_ptr),
    .held_data    (held_data),
    .stream_valid (stream_valid_o),
    .stream_data  (stream_data_o)
  );

  assign busy_o         = (state_q != S_IDLE);
  assign done_o         = (state_q == S_END);
  assign overflow_o     = ovf_q;
  assign rd_req_valid_o = (state_q == S_REQ) && !(cap_q && sink_full);
  assign ram_we_o       = (state_q == S_WRITE);
  assign ram_en_o       = ram_we_o || ((state_q == S_FETCH) && !lptr_q[RAM_AW]);
  assign ram_addr_o     = ram_we_o ? wr_ptr : lptr_q[RAM_AW-1:0];
  assign ram_wdata_o    = held_data;
endmodule

// File: rtl/llw_walker_checker.sv
`timescale 1ns/1ps
module llw_walker_checker #(
  parameter int RAM_AW = 8
) (
  input logic        clk,
  input logic        rst_n,
  input logic        busy_o,
  input logic        done_o,
  input logic        overflow_o,
  input logic        ram_en_o,
  input logic        ram_we_o,
  input logic        rd_req_valid_o,
  input logic        rd_req_ready_i,
  input logic [31:0] rd_req_addr_o,
  input logic        rd_rsp_valid_i,
  input logic        stream_valid_o,
  input logic        cap_q,
  input logic        ev_accept
);
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!ram_en_o && !rd_req_valid_o && !stream_valid_o && !done_o));

  p_done_then_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (!busy_o && !done_o));

  p_one_outstanding_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_valid_o && rd_req_ready_i) |=> !rd_req_valid_o);

  p_req_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_valid_o && !rd_req_ready_i) |=> (rd_req_valid_o && $stable(rd_req_addr_o)));

  p_accept_needs_rsp_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept |-> rd_rsp_valid_i);

  p_write_only_capture_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we_o |-> cap_q);

  p_stream_only_stream_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stream_valid_o |-> (!cap_q && $past(rd_rsp_valid_i)));

  p_overflow_ends_pass_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overflow_o) |-> done_o);
endmodule

bind llw_walker llw_walker_checker #(.RAM_AW(RAM_AW)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .busy_o         (busy_o),
  .done_o         (done_o),
  .overflow_o     (overflow_o),
  .ram_en_o       (ram_en_o),
  .ram_we_o       (ram_we_o),
  .rd_req_valid_o (rd_req_valid_o),
  .rd_req_ready_i (rd_req_ready_i),
  .rd_req_addr_o  (rd_req_addr_o),
  .rd_rsp_valid_i (rd_rsp_valid_i),
  .stream_valid_o (stream_valid_o),
  .cap_q          (cap_q),
  .ev_accept      (ev_accept)
);

// File: tb/llw_walker_test.sv
`timescale 1ns/1ps
module llw_walker_test;
  localparam int AW    = 8;
  localparam int WORDS = 1 << AW;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, start, capture;
  logic [AW-1:0] dbase;
  logic busy, done, ovf, ram_en, ram_we;
  logic [AW-1:0] ram_addr;
  logic [31:0] ram_wdata, ram_rdata;
  logic req_valid, req_ready, rsp_valid;
  logic [31:0] req_addr, rsp_data;
  logic sv;
  logic [31:0] sd;

  llw_walker #(.RAM_AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .capture_i(capture), .data_base_i(dbase),
    .busy_o(busy), .done_o(done), .overflow_o(ovf),
    .ram_en_o(ram_en), .ram_we_o(ram_we), .ram_addr_o(ram_addr),
    .ram_wdata_o(ram_wdata), .ram_rdata_i(ram_rdata),
    .rd_req_valid_o(req_valid), .rd_req_ready_i(req_ready), .rd_req_addr_o(req_addr),
    .rd_rsp_valid_i(rsp_valid), .rd_rsp_data_i(rsp_data),
    .stream_valid_o(sv), .stream_data_o(sd));

  logic [31:0] mem [WORDS];
  logic [31:0] addr_log[$], strm_log[$], exp_addr[$];
  bit          exp_ovf;
  int          wr_count, done_cnt, checks, errors, cyc;
  bit          pend;
  int          dly;
  logic [31:0] paddr;

  function automatic logic [31:0] tgt(input logic [31:0] a);
    return (a * 32'h0001_0003) ^ 32'h5EED_1234;
  endfunction
  function automatic logic [31:0] mk_base(input logic [31:0] byte_addr);
    return 32'h8000_0000 | {4'h0, byte_addr[31:4]};
  endfunction
  function automatic logic [31:0] mk_span(input int d0, input int n0, input int d1, input int n1);
    return {1'b0, 7'(n1), 8'(d1), 1'b0, 7'(n0), 8'(d0)};
  endfunction

  // SRAM model: one-cycle read latency
  always @(posedge clk) begin
    if (ram_en) begin
      if (ram_we) begin mem[ram_addr] <= ram_wdata; wr_count++; end
      else ram_rdata <= mem[ram_addr];
    end
  end

  // target read slave with random ready and latency
  always @(posedge clk) begin
    if (!rst_n) begin
      pend <= 1'b0; rsp_valid <= 1'b0; req_ready <= 1'b0; dly <= 0;
    end else begin
      rsp_valid <= 1'b0;
      req_ready <= ($urandom % 4) != 0;
      if (!pend) begin
        if (req_valid && req_ready) begin
          pend <= 1'b1; paddr <= req_addr; dly <= int'($urandom % 3);
          addr_log.push_back(req_addr);
        end
      end else if (dly == 0) begin
        rsp_valid <= 1'b1; rsp_data <= tgt(paddr); pend <= 1'b0;
      end else dly <= dly - 1;
    end
  end

  always @(posedge clk) begin
    if (sv) strm_log.push_back(sd);
    if (done) done_cnt++;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      chk(1'b0, "R1", "watchdog expired", 32'(cyc), 32'd150000);
      finish_run();
    end
  end

  // independent walk of the list held in mem
  task automatic expect_walk(input bit cap, input int db);
    int lp, off, n, d;
    logic [31:0] base, w;
    logic [15:0] hw;
    bit stop;
    lp = 0; off = 0; base = 0; stop = 0;
    exp_addr.delete(); exp_ovf = 0;
    while (!stop) begin
      if (lp >= WORDS) begin exp_ovf = 1; break; end
      w = mem[lp]; lp++;
      if (w == 0) break;
      if (w[31]) begin base = {w[27:0], 4'h0}; off = 0; end
      else begin
        for (int h = 0; h < 2 && !stop; h++) begin
          hw = (h == 1) ? w[31:16] : w[15:0];
          n = int'(hw[14:8]); d = int'(hw[7:0]);
          if (n != 0) begin
            off += d;
            for (int k = 0; k < n; k++) begin
              if (cap && (db + exp_addr.size()) >= WORDS) begin exp_ovf = 1; stop = 1; break; end
              exp_addr.push_back(base + 32'((off + k) * 4));
            end
          end
        end
      end
    end
  endtask

  task automatic fill_tail(input int from);
    for (int i = from; i < WORDS; i++) mem[i] = 32'hDEAD_0000 + 32'(i);
  endtask

  task automatic run(input bit cap, input int db, input bit restart, input string req);
    int wait_cyc, mism;
    logic [31:0] act_bad, exp_bad;
    expect_walk(cap, db);
    addr_log.delete(); strm_log.delete(); wr_count = 0; done_cnt = 0;
    @(negedge clk); capture = cap; dbase = AW'(db); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(busy, "R1", "busy after start", 32'(busy), 32'd1);
    if (restart) begin
      @(negedge clk); if (busy) start = 1'b1;
      @(negedge clk); start = 1'b0;
    end
    wait_cyc = 0;
    while (!done && wait_cyc < 30000) begin @(negedge clk); wait_cyc++; end
    chk(done, "R1", "done reached", 32'(done), 32'd1);
    @(negedge clk);
    chk(!busy, "R1", "idle after done", 32'(busy), 32'd0);
    repeat (2) @(negedge clk);
    chk(done_cnt == 1, "R1", "done pulse count", 32'(done_cnt), 32'd1);
    mism = 0; act_bad = 0; exp_bad = 0;
    for (int i = 0; i < exp_addr.size(); i++) begin
      if (i >= addr_log.size() || addr_log[i] != exp_addr[i]) begin
        if (mism == 0) begin act_bad = (i < addr_log.size()) ? addr_log[i] : 32'hFFFF_FFFF; exp_bad = exp_addr[i]; end
        mism++;
      end
    end
    chk(addr_log.size() == exp_addr.size(), req, "read count", 32'(addr_log.size()), 32'(exp_addr.size()));
    chk(mism == 0, req, "read address sequence", act_bad, exp_bad);
    chk(ovf == exp_ovf, "R9", "overflow flag", 32'(ovf), 32'(exp_ovf));
    if (cap) begin
      mism = 0; act_bad = 0; exp_bad = 0;
      for (int i = 0; i < exp_addr.size(); i++)
        if (mem[db + i] != tgt(exp_addr[i])) begin
          if (mism == 0) begin act_bad = mem[db + i]; exp_bad = tgt(exp_addr[i]); end
          mism++;
        end
      chk(mism == 0, "R6", "captured words", act_bad, exp_bad);
      chk(wr_count == exp_addr.size(), "R6", "write count", 32'(wr_count), 32'(exp_addr.size()));
      chk(strm_log.size() == 0, "R6", "no stream in capture", 32'(strm_log.size()), 32'd0);
    end else begin
      mism = 0; act_bad = 0; exp_bad = 0;
      for (int i = 0; i < exp_addr.size(); i++)
        if (i >= strm_log.size() || strm_log[i] != tgt(exp_addr[i])) begin
          if (mism == 0) begin act_bad = (i < strm_log.size()) ? strm_log[i] : 32'hFFFF_FFFF; exp_bad = tgt(exp_addr[i]); end
          mism++;
        end
      chk(mism == 0 && strm_log.size() == exp_addr.size(), "R7", "stream values", act_bad, exp_bad);
      chk(wr_count == 0, "R7", "no SRAM writes in stream", 32'(wr_count), 32'd0);
    end
  endtask

  task automatic random_list(output int len);
    int lp, groups, spans;
    lp = 0;
    groups = 1 + int'($urandom % 3);
    for (int g = 0; g < groups; g++) begin
      mem[lp] = mk_base($urandom); lp++;
      spans = 1 + int'($urandom % 3);
      for (int s = 0; s < spans; s++) begin
        mem[lp] = mk_span(int'($urandom % 256), int'($urandom % 6),
                          int'($urandom % 256), int'($urandom % 6));
        lp++;
      end
    end
    mem[lp] = 32'h0; lp++;
    len = lp;
  endtask

  initial begin
    int len, seed_dummy;
    seed_dummy = int'($urandom(32'd4242));
    rst_n = 1'b0; start = 1'b0; capture = 1'b0; dbase = '0;
    checks = 0; errors = 0; cyc = 0;
    for (int i = 0; i < WORDS; i++) mem[i] = 32'h0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk(!busy && !done && !ovf && !ram_en && !req_valid && !sv, "R10", "idle after reset",
        {26'd0, busy, done, ovf, ram_en, req_valid, sv}, 32'd0);

    // R2 R3: two bases, padded single pair, capture, restart attempt while busy
    mem[0] = mk_base(32'h4000_1000);
    mem[1] = mk_span(2, 3, 5, 2);
    mem[2] = mk_base(32'h0000_2000);
    mem[3] = mk_span(0, 1, 1, 0);
    mem[4] = 32'h0;
    fill_tail(5);
    run(1'b1, 5, 1'b1, "R2,R3");

    // R7: same list streamed
    fill_tail(5);
    run(1'b0, 5, 1'b0, "R3");

    // R4: zero-count pair must not move the offset
    mem[0] = mk_base(32'h0000_8000);
    mem[1] = mk_span(3, 0, 2, 1);
    mem[2] = mk_span(7, 0, 1, 2);
    mem[3] = 32'h0;
    fill_tail(4);
    run(1'b0, 4, 1'b0, "R4");

    // R3: largest step and count
    mem[0] = mk_base(32'h1234_5670);
    mem[1] = mk_span(255, 127, 255, 1);
    mem[2] = 32'h0;
    fill_tail(3);
    run(1'b0, 3, 1'b0, "R3");

    // R9: capture region runs out after two words
    mem[0] = mk_base(32'h0000_0100);
    mem[1] = mk_span(0, 5, 1, 0);
    mem[2] = 32'h0;
    fill_tail(3);
    run(1'b1, WORDS - 2, 1'b0, "R9");

    // R9: overflow flag cleared by the next start
    fill_tail(3);
    run(1'b1, 3, 1'b0, "R9");

    // R5: empty list
    mem[0] = 32'h0;
    fill_tail(1);
    run(1'b1, 1, 1'b0, "R5");

    // R9: list with no terminator runs off the SRAM end
    for (int i = 0; i < WORDS; i++) mem[i] = 32'h8000_0000;
    run(1'b0, 0, 1'b0, "R9");

    // random lists in both modes (R2 R3 R5 R6 R7)
    for (int r = 0; r < 10; r++) begin
      random_list(len);
      fill_tail(len);
      run(r[0], len + int'($urandom % 8), 1'b0, "R3");
    end

    finish_run();
  end
endmodule